// File: doc/BRIEF.md
# DS3 Maintenance Signal Classifier

This block watches an already-framed DS3 receive bit stream and decides which maintenance condition the far end is sending: the alarm indication signal, the idle code, or a yellow (remote alarm) indication. It also reports which DS3 framing format the far end uses. An upstream framer presents each received bit with a qualifier and a set of position strobes. The strobes mark overhead bits, the two X-bits, every C-bit (with its subframe and position) and the last bit of each M-frame. Framing-valid, parity-valid, loss-of-signal and out-of-frame arrive as inputs.

In DS3 mode, each payload run between overhead bits must restart its pattern. One mismatch anywhere in an M-frame disqualifies that M-frame. The AIS and idle results refresh only at M-frame ends. In E3 mode the rules change: AIS becomes a run of unframed ones one E3 frame long, yellow follows the A-bit, and idle and the format code are held at zero. A three-bit shadow register keeps every alarm that has been seen since the last read. A read strobe reloads it from the live alarms.

Top module: `ds3_maint_classifier`

## Requirements
- R1: In DS3 mode, `ais_det` is 1 after an M-frame only if that M-frame met all of these: every C-bit 0, both X-bits equal, and every payload bit following the pattern 1,0,1,0,... that starts with 1.
- R2: In DS3 mode, `idle_det` is 1 after an M-frame only if that M-frame met all of these: the three C-bits of subframe 3 were 0, both X-bits were equal, and every payload bit followed 1,1,0,0,... starting with 1,1.
- R3: The expected payload pattern restarts at its first element on the first payload bit after every overhead bit (`rx_oh`=1).
- R4: If `frame_ok` or `parity_ok` is low on any valid bit of an M-frame, AIS and idle are 0 after that M-frame.
- R5: In DS3 mode, yellow becomes 1 for the M-frame that follows an M-frame whose X-bits were both 0, and 0 otherwise.
- R6: `yel_det` is 0 whenever `los_in`, `oof_in` or `ais_det` is 1.
- R7: In DS3 mode, `fmt_id` is set at each M-frame end from subframe 1 of that M-frame. It is 2'b01 (C-bit parity) if the C-bit at position 1 was 1. Otherwise it is 2'b10 (Syntran) if the C-bit at position 2 was 1. Otherwise it is 2'b00 (M13). The value 2'b11 never appears.
- R8: In E3 mode, `ais_det` is 1 once `E3_FRAME_BITS` consecutive valid bits have been 1, and goes to 0 on the next valid 0.
- R9: In E3 mode, `idle_det` and `fmt_id` are 0, and yellow takes the value of the bit marked by `x_strobe` (the A-bit).
- R10: `sh_status` = {idle, yellow, AIS}. Without a read, each bit of `sh_status` stays 1 from the cycle after the live alarm was 1.
- R11: In the cycle after `rd_strobe`, `sh_status` equals the live {idle_det, yel_det, ais_det} of the cycle in which the strobe was high.
- R12: In DS3 mode, `ais_det` and `idle_det` change only in the cycle after a valid bit with `mframe_end`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e3_mode | input | 1 | 1 selects the E3 rules |
| rx_valid | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received bit value |
| rx_oh | input | 1 | Bit is an overhead bit |
| x_strobe | input | 1 | Bit is an X-bit (the A-bit in E3 mode) |
| c_strobe | input | 1 | Bit is a C-bit |
| c_subframe | input | 3 | Subframe of the C-bit, 1 to 7 |
| c_pos | input | 2 | Position of the C-bit in its subframe, 1 to 3 |
| mframe_end | input | 1 | Bit is the last bit of an M-frame |
| frame_ok | input | 1 | Framer reports valid framing |
| parity_ok | input | 1 | Parity checker reports valid parity |
| los_in | input | 1 | Loss-of-signal alarm |
| oof_in | input | 1 | Out-of-frame alarm |
| rd_strobe | input | 1 | Controller read of the shadow register |
| ais_det | output | 1 | AIS detected |
| idle_det | output | 1 | Idle code detected |
| yel_det | output | 1 | Yellow alarm detected |
| fmt_id | output | 2 | Detected DS3 format |
| sh_status | output | 3 | Sticky shadow {idle, yellow, AIS} |

## Verification
The assertions rely on the framer's strobes being consistent with each other. Each M-frame carries exactly two X-bits, every C-bit and X-bit is also marked as overhead, and `e3_mode` changes only while reset is held. The stimulus builds whole M-frames through a single task: seven subframes, each opening with an overhead bit and holding three C-bits, with five payload bits after every overhead bit. The odd payload length means a classifier that does not restart its phase would fail. `los_in` and `oof_in` change only between M-frames, and every mode change goes through reset.

// File: rtl/ds3_maint_classifier.sv
module ds3_maint_classifier #(
  parameter int E3_FRAME_BITS = 1536,
  localparam int CW = $clog2(E3_FRAME_BITS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       e3_mode,
  input  logic       rx_valid,
  input  logic       rx_bit,
  input  logic       rx_oh,
  input  logic       x_strobe,
  input  logic       c_strobe,
  input  logic [2:0] c_subframe,
  input  logic [1:0] c_pos,
  input  logic       mframe_end,
  input  logic       frame_ok,
  input  logic       parity_ok,
  input  logic       los_in,
  input  logic       oof_in,
  input  logic       rd_strobe,
  output logic       ais_det,
  output logic       idle_det,
  output logic       yel_det,
  output logic [1:0] fmt_id,
  output logic [2:0] sh_status
);

  logic [1:0]    ph;
  logic          ais_c, idle_c, xeq_c, xlow_c, xseen_c, xfirst, fok_c, aic_c, syn_c;
  logic          ais_q, idle_q, yel_q;
  logic [1:0]    fmt_q;
  logic [CW-1:0] ones;

  wire pay  = rx_valid & ~rx_oh;
  wire cbit = rx_valid & c_strobe;
  wire xs   = rx_valid & x_strobe;
  wire sf1  = c_subframe == 3'd1;

  wire ais_n  = ais_c & ~(pay & (rx_bit != ~ph[0])) & ~(cbit & rx_bit);
  wire idle_n = idle_c & ~(pay & (rx_bit != ~ph[1])) & ~(cbit & rx_bit & (c_subframe == 3'd3));
  wire xeq_n  = xeq_c & ~(xs & xseen_c & (rx_bit != xfirst));
  wire xlow_n = xlow_c & ~(xs & rx_bit);
  wire xseen_n = xseen_c | xs;
  wire fok_n  = fok_c & (~rx_valid | (frame_ok & parity_ok));
  wire aic_n  = (cbit & sf1 & (c_pos == 2'd1)) ? rx_bit : aic_c;
  wire syn_n  = (cbit & sf1 & (c_pos == 2'd2)) ? rx_bit : syn_c;
  wire e3_full = ones == CW'(E3_FRAME_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0;
      {ais_c, idle_c, xeq_c, xlow_c, fok_c} <= '1;
      {xseen_c, xfirst, aic_c, syn_c} <= '0;
      {ais_q, idle_q, yel_q} <= '0;
      fmt_q <= '0;
      ones <= '0;
    end else if (rx_valid && e3_mode) begin
      ones <= !rx_bit ? '0 : (e3_full ? ones : ones + 1'b1);
      if (x_strobe) yel_q <= rx_bit;
    end else if (rx_valid) begin
      ph <= rx_oh ? 2'd0 : ph + 2'd1;
      if (xs && !xseen_c) xfirst <= rx_bit;
      if (mframe_end) begin
        ais_q  <= ais_n & xeq_n & fok_n;
        idle_q <= idle_n & xeq_n & fok_n;
        yel_q  <= xlow_n & xseen_n;
        fmt_q  <= aic_n ? 2'b01 : (syn_n ? 2'b10 : 2'b00);
        {ais_c, idle_c, xeq_c, xlow_c, fok_c} <= '1;
        {xseen_c, aic_c, syn_c} <= '0;
      end else begin
        {ais_c, idle_c, xeq_c, xlow_c, fok_c} <= {ais_n, idle_n, xeq_n, xlow_n, fok_n};
        {xseen_c, aic_c, syn_c} <= {xseen_n, aic_n, syn_n};
      end
    end
  end

  assign ais_det  = e3_mode ? e3_full : ais_q;
  assign idle_det = ~e3_mode & idle_q;
  assign yel_det  = yel_q & ~los_in & ~oof_in & ~ais_det;
  assign fmt_id   = e3_mode ? 2'b00 : fmt_q;

  wire [2:0] live = {idle_det, yel_det, ais_det};

  always_ff @(posedge clk) begin
    if (!rst_n)         sh_status <= '0;
    else if (rd_strobe) sh_status <= live;
    else                sh_status <= sh_status | live;
  end

endmodule

module ds3_maint_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       e3_mode,
  input logic       rx_valid,
  input logic       mframe_end,
  input logic       los_in,
  input logic       oof_in,
  input logic       rd_strobe,
  input logic       ais_det,
  input logic       idle_det,
  input logic       yel_det,
  input logic [1:0] fmt_id,
  input logic [2:0] sh_status
);

  // R6
  yel_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los_in || oof_in || ais_det) |-> !yel_det);

  // R9
  e3_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e3_mode |-> (!idle_det && fmt_id == 2'b00));

  // R7
  fmt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_id != 2'b11);

  // R10
  shadow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((sh_status & $past(sh_status)) == $past(sh_status)));

  // R11
  shadow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (sh_status == $past({idle_det, yel_det, ais_det})));

  // R12
  mframe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!e3_mode && !(rx_valid && mframe_end)) |=> (e3_mode || ($stable(ais_det) && $stable(idle_det))));

endmodule

bind ds3_maint_classifier ds3_maint_classifier_chk chk_i (.*);

// File: tb/ds3_maint_classifier_test.sv
module ds3_maint_classifier_test;

  localparam int NE3 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0, e3_mode = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, rx_oh = 1'b0;
  logic x_strobe = 1'b0, c_strobe = 1'b0, mframe_end = 1'b0;
  logic [2:0] c_subframe = '0;
  logic [1:0] c_pos = '0;
  logic frame_ok = 1'b1, parity_ok = 1'b1, los_in = 1'b0, oof_in = 1'b0, rd_strobe = 1'b0;
  logic ais_det, idle_det, yel_det;
  logic [1:0] fmt_id;
  logic [2:0] sh_status;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic ais, idle, yel;
    logic [1:0] fmt;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  ds3_maint_classifier #(.E3_FRAME_BITS(NE3)) uut (.*);

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic drive(logic b, logic oh, logic xs, logic cs, int sf, int pos, logic me);
    rx_valid = 1'b1; rx_bit = b; rx_oh = oh; x_strobe = xs; c_strobe = cs;
    c_subframe = 3'(sf); c_pos = 2'(pos); mframe_end = me;
    @(negedge clk);
  endtask

  task automatic idle_cycles(int n);
    rx_valid = 1'b0; x_strobe = 1'b0; c_strobe = 1'b0; mframe_end = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic e3);
    rst_n = 1'b0; e3_mode = e3;
    idle_cycles(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 = alternating, 1 = idle code, 2 = all zero payload
  task automatic payload(int kind, int err_at, inout int idx, input logic last);
    for (int k = 0; k < 5; k++) begin
      logic b;
      b = (kind == 0) ? (k % 2 == 0) : (kind == 1) ? ((k % 4) < 2) : 1'b0;
      if (idx == err_at) b = ~b;
      idx++;
      drive(b, 1'b0, 1'b0, 1'b0, 0, 0, last && k == 4);
    end
  endtask

  task automatic send_mframe(string tag, int kind, logic [20:0] cv, logic x1, logic x2,
                             logic fok, int err_at);
    exp_t e;
    int idx = 0;
    e.ais  = kind == 0 && err_at < 0 && cv == '0 && x1 == x2 && fok;
    e.idle = kind == 1 && err_at < 0 && cv[8:6] == '0 && x1 == x2 && fok;
    e.yel  = !x1 && !x2 && !los_in && !oof_in && !e.ais;
    e.fmt  = cv[0] ? 2'b01 : (cv[1] ? 2'b10 : 2'b00);
    e.tag  = tag;
    sb.push_back(e);
    frame_ok = fok;
    for (int sf = 0; sf < 7; sf++) begin
      drive(sf == 0 ? x1 : (sf == 1 ? x2 : 1'b0), 1'b1, sf < 2, 1'b0, 0, 0, 1'b0);
      payload(kind, err_at, idx, 1'b0);
      for (int p = 0; p < 3; p++) begin
        drive(cv[sf*3+p], 1'b1, 1'b0, 1'b1, sf + 1, p + 1, 1'b0);
        payload(kind, err_at, idx, sf == 6 && p == 2);
      end
    end
    frame_ok = 1'b1;
    idle_cycles(2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && rx_valid && mframe_end && !e3_mode) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          chk("R12 unexpected frame end", 3'd1, 3'd0);
        end else begin
          e = sb.pop_front();
          chk({e.tag, " ais"}, {2'b0, ais_det}, {2'b0, e.ais});
          chk({e.tag, " idle"}, {2'b0, idle_det}, {2'b0, e.idle});
          chk({e.tag, " yel"}, {2'b0, yel_det}, {2'b0, e.yel});
          chk({e.tag, " fmt"}, {1'b0, fmt_id}, {1'b0, e.fmt});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    chk("reset outputs", {ais_det, idle_det, yel_det}, 3'b000);
    chk("reset fmt/shadow", {fmt_id, 1'b0}, 3'b000);
    chk("reset shadow", sh_status, 3'b000);

    send_mframe("R1 R3 clean AIS", 0, 21'h0, 1'b1, 1'b1, 1'b1, -1);
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    chk("R12 AIS held mid-frame", {2'b0, ais_det}, 3'b001);
    do_reset(1'b0);

    send_mframe("R1 payload error", 0, 21'h0, 1'b1, 1'b1, 1'b1, 37);
    send_mframe("R1 C-bit set", 0, 21'h00400, 1'b1, 1'b1, 1'b1, -1);
    send_mframe("R1 X unequal", 0, 21'h0, 1'b1, 1'b0, 1'b1, -1);
    send_mframe("R4 framing bad", 0, 21'h0, 1'b1, 1'b1, 1'b0, -1);
    send_mframe("R2 R3 idle", 1, 21'h1F03F, 1'b0, 1'b0, 1'b1, -1);
    send_mframe("R2 sf3 C-bit set", 1, 21'h00080, 1'b1, 1'b1, 1'b1, -1);
    send_mframe("R2 idle payload error", 1, 21'h0, 1'b1, 1'b1, 1'b1, 100);
    send_mframe("R4 R2 framing bad", 1, 21'h0, 1'b1, 1'b1, 1'b0, -1);
    send_mframe("R5 R7 yellow", 2, 21'h00001, 1'b0, 1'b0, 1'b1, -1);
    send_mframe("R6 R7 yellow under AIS", 0, 21'h0, 1'b0, 1'b0, 1'b1, -1);
    los_in = 1'b1;
    send_mframe("R6 R7 yellow under LOS", 2, 21'h00002, 1'b0, 1'b0, 1'b1, -1);
    los_in = 1'b0;
    send_mframe("R5 R7 no yellow", 2, 21'h00003, 1'b1, 1'b0, 1'b1, -1);

    do_reset(1'b0);
    send_mframe("R10 AIS for shadow", 0, 21'h0, 1'b1, 1'b1, 1'b1, -1);
    send_mframe("R10 plain frame", 2, 21'h0, 1'b1, 1'b1, 1'b1, -1);
    chk("R10 shadow keeps AIS", sh_status, 3'b001);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk("R11 shadow reload", sh_status, 3'b000);

    do_reset(1'b1);
    for (int k = 0; k < NE3 - 1; k++) drive(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    chk("R8 one bit short", {2'b0, ais_det}, 3'b000);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    chk("R8 full frame of ones", {2'b0, ais_det}, 3'b001);
    chk("R6 yellow off under E3 AIS", {2'b0, yel_det}, 3'b000);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
    chk("R8 zero clears AIS", {2'b0, ais_det}, 3'b000);
    chk("R9 A-bit low", {2'b0, yel_det}, 3'b000);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
    chk("R9 A-bit high", {2'b0, yel_det}, 3'b001);
    chk("R9 idle and fmt zero", {idle_det, fmt_id}, 3'b000);
    oof_in = 1'b1;
    #1;
    chk("R6 OOF masks yellow", {2'b0, yel_det}, 3'b000);
    oof_in = 1'b0;
    idle_cycles(2);

    if (sb.size() != 0) chk("R12 frames left unchecked", 3'(sb.size()), 3'd0);
    finish_run();
  end

endmodule